// File: doc/BRIEF.md
# Triple-Redundant Self-Scrubbing Configuration Store

This block keeps 512 bits of chip configuration as 32 words of 16 bits, with each bit held in three independent copies. Writes arrive on one shared address and data bus, but with three separate load strobes. Each strobe has its own 5-to-32 word decoder and writes only its own copy. A glitch on one strobe line can therefore damage at most one copy of one word. Reads always return the bitwise two-of-three majority of the copies, registered one cycle after the request.

A background scrubber visits one word per clock cycle and wraps from the last word back to the first. Wherever a copy disagrees with the vote, it writes the voted value back into that copy. The scrubber halts while any load strobe is high, so a scrub rewrite can never collide with a write. A saturating counter totals the copy bits that have been repaired. A sticky flag records that a visited word had all three copies pairwise different, which points to a multi-bit upset.

Neither port applies back-pressure. Every write and every read request is taken in the cycle it is presented. Read data comes back exactly one cycle later, marked by a one-cycle valid pulse.

Top module: `tmr_cfg_store`

## Requirements
- R1: After reset every copy of every word is 0, `fix_count` is 0, `multi_err` is 0 and `rd_valid` is 0.
- R2: A write with all three bits of `wr_load` set stores `wr_data` into all copies of word `wr_addr` at that clock edge and leaves every other word unchanged.
- R3: Bit i of `wr_load` (i = 0, 1, 2) writes only copy i. A write on a single lane does not change the read value of the word. A write on two lanes does change it.
- R4: `rd_req` sampled high at clock edge N gives `rd_valid` = 1 and `rd_data` = bitwise majority of the three copies of `rd_addr` after edge N. `rd_valid` is 0 after any edge where `rd_req` was low.
- R5: The scrubber visits one word per cycle in ascending order and wraps from word 31 to word 0. Within 33 cycles with `wr_load` = 0, every copy that disagrees with the vote is rewritten with the voted value.
- R6: While any bit of `wr_load` is high, the scrubber neither moves nor repairs, and `fix_count` holds its value.
- R7: `fix_count` rises by the number of copy bits each scrub step rewrites, and it saturates at 65535.
- R8: `multi_err` goes to 1 when the scrubber visits a word whose three copies are pairwise different. It stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_load | input | 3 | Per-copy load strobes; bit i writes copy i |
| wr_addr | input | 5 | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_req | input | 1 | Read request, always accepted |
| rd_addr | input | 5 | Word address of the read |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 16 | Majority-voted read data |
| fix_count | output | 16 | Saturating count of repaired copy bits |
| multi_err | output | 1 | Sticky flag for three pairwise-different copies |

## Verification
The assertions assume that the inputs are quiet whenever reset is low. They also assume that `rd_req` and `wr_load` are sampled cleanly at the clock edge, since a read is always taken and the scrubber's stall depends on the load strobes alone. The stimulus changes every input on the falling edge and holds it over the next rising edge. Load strobes are kept high across back-to-back writes whenever a test must damage copies before the scrubber gets a chance to run. Fault injection uses only a partial `wr_load` pattern, so every upset enters through the real write path.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANES  = 3;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  function automatic logic [WORD_W-1:0] vote3(input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] b,
                                              input logic [WORD_W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_word_decoder.sv
module tmr_word_decoder #(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  sel
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (en && addr == ADDR_W'(i)) sel[i] = 1'b1;
    end
  end

  // R2
  one_word_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R2
  sel_when_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(sel) == 1);
endmodule

// File: rtl/tmr_copy_bank.sv
module tmr_copy_bank #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEPTH-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fix_en,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [WORD_W-1:0] fix_data,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [WORD_W-1:0] scan_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[w] <= '0;
      end else if (wr_sel[w]) begin
        mem_q[w] <= wr_data;
      end else if (fix_en && fix_addr == ADDR_W'(w)) begin
        mem_q[w] <= fix_data;
      end
    end
  end

  assign scan_word = mem_q[scan_addr];
  assign rd_word   = mem_q[rd_addr];

  // R5
  fix_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && !(|wr_sel)) |=> mem_q[$past(fix_addr)] == $past(fix_data));
endmodule

// File: rtl/tmr_scrubber.sv
module tmr_scrubber
  import tmr_cfg_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned D_W = WORD_W,
  parameter int unsigned C_W = CNT_W,
  localparam int unsigned NWORDS = 1 << A_W,
  localparam int unsigned SUM_W  = $clog2(LANES * D_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pause,
  input  logic [LANES-1:0][D_W-1:0]  copy_words,
  output logic [A_W-1:0]             ptr,
  output logic [LANES-1:0]           fix_en,
  output logic [D_W-1:0]             fix_data,
  output logic [C_W-1:0]             fix_count,
  output logic                       multi_err
);
  localparam logic [C_W-1:0] CNT_MAX = '1;

  logic [A_W-1:0]   ptr_q;
  logic [C_W-1:0]   cnt_q;
  logic             multi_q;
  logic [D_W-1:0]   voted;
  logic [SUM_W-1:0] bits_fixed;
  logic             all_differ;
  logic [C_W:0]     cnt_sum;

  assign voted    = vote3(copy_words[0], copy_words[1], copy_words[2]);
  assign fix_data = voted;

  always_comb begin
    bits_fixed = '0;
    for (int l = 0; l < LANES; l++) begin
      fix_en[l] = !pause && (copy_words[l] != voted);
      for (int b = 0; b < D_W; b++) begin
        bits_fixed = bits_fixed + SUM_W'(!pause && (copy_words[l][b] != voted[b]));
      end
    end
  end

  assign all_differ = (copy_words[0] != copy_words[1]) &&
                      (copy_words[1] != copy_words[2]) &&
                      (copy_words[0] != copy_words[2]);

  assign cnt_sum = {1'b0, cnt_q} + (C_W+1)'(bits_fixed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      cnt_q   <= '0;
      multi_q <= 1'b0;
    end else if (!pause) begin
      ptr_q <= (ptr_q == A_W'(NWORDS - 1)) ? '0 : ptr_q + 1'b1;
      cnt_q <= cnt_sum[C_W] ? CNT_MAX : cnt_sum[C_W-1:0];
      if (all_differ) multi_q <= 1'b1;
    end
  end

  assign ptr       = ptr_q;
  assign fix_count = cnt_q;
  assign multi_err = multi_q;

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause |=> $stable(ptr_q) && $stable(cnt_q));
  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause && ptr_q == A_W'(NWORDS - 1)) |=> ptr_q == '0);
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause && ptr_q != A_W'(NWORDS - 1)) |=> ptr_q == $past(ptr_q) + 1'b1);
  // R7
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q >= $past(cnt_q));
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  // R8
  multi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_q |=> multi_q);
endmodule

// File: rtl/tmr_cfg_store.sv
module tmr_cfg_store
  import tmr_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        wr_load,
  input  logic [4:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_req,
  input  logic [4:0]        rd_addr,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [15:0]       fix_count,
  output logic              multi_err
);
  logic [LANES-1:0][DEPTH-1:0]  lane_sel;
  logic [LANES-1:0][WORD_W-1:0] scan_words;
  logic [LANES-1:0][WORD_W-1:0] rd_words;
  logic [LANES-1:0]             fix_en;
  logic [WORD_W-1:0]            fix_data;
  logic [ADDR_W-1:0]            scan_ptr;
  logic                         pause;
  logic                         rd_valid_q;
  logic [WORD_W-1:0]            rd_data_q;

  assign pause = |wr_load;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tmr_word_decoder #(.ADDR_W(ADDR_W)) dec_i (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (wr_load[l]),
      .addr (wr_addr),
      .sel  (lane_sel[l])
    );
    tmr_copy_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (lane_sel[l]),
      .wr_data  (wr_data),
      .fix_en   (fix_en[l]),
      .fix_addr (scan_ptr),
      .fix_data (fix_data),
      .scan_addr(scan_ptr),
      .scan_word(scan_words[l]),
      .rd_addr  (rd_addr),
      .rd_word  (rd_words[l])
    );
  end

  tmr_scrubber #(.A_W(ADDR_W), .D_W(WORD_W), .C_W(CNT_W)) scrub_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause     (pause),
    .copy_words(scan_words),
    .ptr       (scan_ptr),
    .fix_en    (fix_en),
    .fix_data  (fix_data),
    .fix_count (fix_count),
    .multi_err (multi_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) rd_data_q <= vote3(rd_words[0], rd_words[1], rd_words[2]);
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R4
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R4
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R6
  no_fix_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> fix_en == '0);
  // R3
  lane_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_load[0] |-> lane_sel[0] == '0);
endmodule

// File: tb/tmr_cfg_store_tb_top.sv
`timescale 1ns/1ps
module tmr_cfg_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wr_load = '0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [15:0] fix_count;
  logic        multi_err;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 0;
  logic [15:0] model [32];

  always #5 clk = ~clk;

  tmr_cfg_store dut_i (
    .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .fix_count(fix_count),
    .multi_err(multi_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] lanes, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_load = lanes; wr_addr = a; wr_data = d;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_load = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
    @(negedge clk);
    wr_load = '0; rd_req = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    check(req, {31'b0, rd_valid}, 32'd1);
    check(req, {16'b0, rd_data}, {16'b0, exp});
    rd_req = 1'b0;
    @(negedge clk);
    check(req, {31'b0, rd_valid}, 32'd0);
  endtask

  function automatic int bits(input logic [15:0] v);
    return $countones(v);
  endfunction

  task automatic t_reset();
    // R1
    check("R1 fix_count", {16'b0, fix_count}, 0);
    check("R1 multi_err", {31'b0, multi_err}, 0);
    check("R1 rd_valid", {31'b0, rd_valid}, 0);
    read_chk("R1 word0", 5'd0, 16'h0000);
    read_chk("R1 word31", 5'd31, 16'h0000);
  endtask

  task automatic t_full_write();
    // R2
    do_write(3'b111, 5'd3, 16'hA5C3);
    idle(1);
    model[3] = 16'hA5C3;
    read_chk("R2 written word", 5'd3, 16'hA5C3);
    read_chk("R2 neighbour word", 5'd4, 16'h0000);
    read_chk("R2 neighbour word", 5'd2, 16'h0000);
    do_write(3'b111, 5'd31, 16'h8001);
    idle(1);
    model[31] = 16'h8001;
    read_chk("R2 top word", 5'd31, 16'h8001);
  endtask

  task automatic t_glitch_fix();
    do_write(3'b111, 5'd5, 16'h1234);
    do_write(3'b001, 5'd5, 16'hFFFF);
    idle(1);
    model[5] = 16'h1234;
    // R3 single-lane write must not change the voted value
    read_chk("R3 single lane", 5'd5, 16'h1234);
    exp_cnt += bits(16'hFFFF ^ 16'h1234);
    idle(40);
    // R5 repair of copy 0; R7 count of repaired bits
    check("R7 count after repair", {16'b0, fix_count}, exp_cnt);
    do_write(3'b010, 5'd5, 16'hEDCB);
    idle(1);
    read_chk("R5 copy0 repaired", 5'd5, 16'h1234);
    exp_cnt += 16;
    idle(40);
    check("R7 count second repair", {16'b0, fix_count}, exp_cnt);
    // R3 two-lane write changes the vote
    do_write(3'b011, 5'd5, 16'h5555);
    idle(1);
    model[5] = 16'h5555;
    read_chk("R3 two lanes", 5'd5, 16'h5555);
    exp_cnt += bits(16'h5555 ^ 16'h1234);
    idle(40);
    check("R7 count third repair", {16'b0, fix_count}, exp_cnt);
    check("R8 no false flag", {31'b0, multi_err}, 0);
  endtask

  task automatic t_pause();
    // R6
    do_write(3'b100, 5'd7, 16'h00FF);
    for (int i = 0; i < 40; i++) do_write(3'b111, 5'd20, 16'h0F0F);
    model[20] = 16'h0F0F;
    @(negedge clk);
    check("R6 count held during writes", {16'b0, fix_count}, exp_cnt);
    exp_cnt += 8;
    idle(40);
    check("R6 repair after release", {16'b0, fix_count}, exp_cnt);
    read_chk("R6 word7", 5'd7, 16'h0000);
    read_chk("R6 word20", 5'd20, 16'h0F0F);
  endtask

  task automatic t_multi();
    // R8
    do_write(3'b001, 5'd9, 16'h00FF);
    do_write(3'b010, 5'd9, 16'h0F0F);
    idle(1);
    model[9] = 16'h000F;
    read_chk("R8 voted three-way", 5'd9, 16'h000F);
    exp_cnt += 12;
    idle(40);
    check("R8 flag set", {31'b0, multi_err}, 1);
    check("R7 three-way repair count", {16'b0, fix_count}, exp_cnt);
    idle(40);
    check("R8 flag sticky", {31'b0, multi_err}, 1);
    read_chk("R8 word after repair", 5'd9, 16'h000F);
  endtask

  task automatic t_saturate();
    // R7 saturation, R5 sweep covers all words incl. wrap
    for (int r = 0; r < 130; r++) begin
      for (int w = 0; w < 32; w++) do_write(3'b001, w[4:0], ~model[w]);
      idle(36);
      if (r == 0) begin
        exp_cnt += 512;
        check("R5 full sweep repaired", {16'b0, fix_count}, exp_cnt);
      end
    end
    check("R7 saturated", {16'b0, fix_count}, 32'hFFFF);
    read_chk("R5 word0 restored", 5'd0, model[0]);
    read_chk("R5 word31 restored", 5'd31, model[31]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_glitch_fix();
    t_pause();
    t_multi();
    t_saturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule